// File: doc/BRIEF.md
# Address-Match Breakpoint Comparator

This block watches a hart's instruction stream and its data accesses, and compares both against a bank of address-match triggers held in the debug CSR file. Each trigger supplies a control word and a compare address. The control word selects the trigger flavour, which of instruction fetch, load and store it watches, the privilege levels it is armed in, and the action to take. A trigger fires only when all of these conditions hold:

- the address is exactly equal to the compare value;
- the access kind is enabled;
- the current privilege, together with the virtualization state, is enabled.

When a trigger fires, the block raises a breakpoint-exception request and reports which trigger fired. The request is registered once. The pipeline applies it to the instruction or access that was presented, before that instruction or access takes effect.

Two trigger flavours are recognised. The classic flavour is silent whenever the hart runs virtualized. The newer flavour has its own enable bits for virtual user and virtual supervisor mode. All other flavour codes are inert. When several triggers hit in the same cycle, the lowest-numbered one is reported.

Top module: `bkpt_addr_match`

## Requirements
- R1: The flavour code sits in the top four bits of a control word. Only code 2 (classic) and code 6 (newer) can fire. Any other code never fires.
- R2: Control bit 2 arms instruction matching. A hit needs `pc_valid` high and `pc` equal to the compare value.
- R3: Control bit 0 arms load matching and control bit 1 arms store matching. A hit needs `mem_valid` high, `mem_addr` equal to the compare value, and `mem_is_store` (0 = load, 1 = store) of the armed kind.
- R4: Outside virtualization, a trigger is armed for privilege code p (0 user, 1 supervisor, 3 machine) only when control bit 3+p is set. Privilege code 2 never fires.
- R5: A classic (code 2) trigger never fires while `virt` is high.
- R6: While `virt` is high, a newer (code 6) trigger is armed in privilege 0 by bit 23 and in privilege 1 by bit 24. The user, supervisor and machine bits are then ignored, and any other privilege never fires.
- R7: A trigger fires only when its action field, bits 15:12, is zero (the breakpoint-exception action).
- R8: When several triggers hit in one cycle, `bkpt_idx` reports the lowest index.
- R9: `bkpt_fire` and `bkpt_idx` are registered. They reflect the inputs sampled at the previous rising clock edge. `bkpt_idx` is 0 whenever `bkpt_fire` is low.
- R10: During reset, `bkpt_fire` and `bkpt_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_ctrl | input | NUM_TRIG*XLEN | Per-trigger control words |
| trig_cmp | input | NUM_TRIG*XLEN | Per-trigger compare addresses |
| pc_valid | input | 1 | Instruction address is valid this cycle |
| pc | input | XLEN | Instruction address |
| mem_valid | input | 1 | Data access is valid this cycle |
| mem_is_store | input | 1 | 1 = store, 0 = load |
| mem_addr | input | XLEN | Data access address |
| priv | input | 2 | Current privilege code |
| virt | input | 1 | Hart is virtualized |
| bkpt_fire | output | 1 | Breakpoint-exception request |
| bkpt_idx | output | IDX_W | Index of the firing trigger |

## Verification
Instruction and data addresses are each tried on the exact compare value and one word away. This shows that the match is equality only. Loads and stores are driven against load-only and store-only triggers, which tells the kind gating apart from the address compare. Every privilege code is swept with virtualization both off and on, across both flavours, which separates the classic flavour's blanket silence from the newer flavour's virtual-mode bits. Finally, several triggers are armed on one address to expose the lowest-index priority, and a non-zero action field and foreign flavour codes are shown to stay silent.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam logic [3:0] FLAV_CLASSIC = 4'd2;
  localparam logic [3:0] FLAV_NEWER   = 4'd6;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // Privilege gate: usm = {M, S, U} enables, vsu = {VS, VU} enables.
  function automatic logic priv_gate(input logic [2:0] usm, input logic [1:0] vsu,
                                     input logic newer, input logic [1:0] prv,
                                     input logic vmode);
    logic ok;
    ok = 1'b0;
    if (vmode) begin
      if (newer) begin
        case (prv)
          PRIV_U:  ok = vsu[0];
          PRIV_S:  ok = vsu[1];
          default: ok = 1'b0;
        endcase
      end
    end else begin
      case (prv)
        PRIV_U:  ok = usm[0];
        PRIV_S:  ok = usm[1];
        PRIV_M:  ok = usm[2];
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

  // Access-kind gate: rwx = {exec, store, load}.
  function automatic logic kind_gate(input logic [2:0] rwx, input logic ex_hit,
                                     input logic dat_hit, input logic is_st);
    return (rwx[2] & ex_hit) | (rwx[0] & dat_hit & ~is_st) | (rwx[1] & dat_hit & is_st);
  endfunction
endpackage

// File: rtl/bkpt_trig_cmp.sv
module bkpt_trig_cmp
  import bkpt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] ctrl,
  input  logic [XLEN-1:0] cmp,
  input  logic            pc_valid,
  input  logic [XLEN-1:0] pc,
  input  logic            mem_valid,
  input  logic            mem_is_store,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [1:0]      priv,
  input  logic            virt,
  output logic            hit
);
  localparam int FLAV_LSB = XLEN - 4;

  logic [3:0] flavour;
  logic       is_classic, is_newer, action_ok, priv_ok, kind_ok;
  logic       pc_eq, mem_eq;
  logic       unused_bits;

  assign flavour    = ctrl[XLEN-1:FLAV_LSB];
  assign is_classic = (flavour == FLAV_CLASSIC);
  assign is_newer   = (flavour == FLAV_NEWER);
  assign action_ok  = (ctrl[15:12] == 4'd0);

  assign pc_eq  = pc_valid && (pc == cmp);
  assign mem_eq = mem_valid && (mem_addr == cmp);

  assign priv_ok = priv_gate({ctrl[6], ctrl[4], ctrl[3]}, ctrl[24:23], is_newer, priv, virt);
  assign kind_ok = kind_gate(ctrl[2:0], pc_eq, mem_eq, mem_is_store);

  assign hit = (is_classic | is_newer) & action_ok & priv_ok & kind_ok;

  assign unused_bits = ^{ctrl[FLAV_LSB-1:25], ctrl[22:16], ctrl[11:7], ctrl[5]};
endmodule

// File: rtl/bkpt_prio_enc.sv
module bkpt_prio_enc #(
  parameter int NUM   = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM-1:0]   req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & ((NUM'(1) << idx) - NUM'(1))) == '0))); // R8
endmodule

// File: rtl/bkpt_addr_match.sv
module bkpt_addr_match
  import bkpt_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_TRIG-1:0][XLEN-1:0] trig_ctrl,
  input  logic [NUM_TRIG-1:0][XLEN-1:0] trig_cmp,
  input  logic                          pc_valid,
  input  logic [XLEN-1:0]               pc,
  input  logic                          mem_valid,
  input  logic                          mem_is_store,
  input  logic [XLEN-1:0]               mem_addr,
  input  logic [1:0]                    priv,
  input  logic                          virt,
  output logic                          bkpt_fire,
  output logic [IDX_W-1:0]              bkpt_idx
);
  logic [NUM_TRIG-1:0] hit_vec;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    bkpt_trig_cmp #(.XLEN(XLEN)) u_cmp (
      .ctrl(trig_ctrl[g]), .cmp(trig_cmp[g]),
      .pc_valid(pc_valid), .pc(pc),
      .mem_valid(mem_valid), .mem_is_store(mem_is_store), .mem_addr(mem_addr),
      .priv(priv), .virt(virt), .hit(hit_vec[g])
    );

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_ctrl[g][XLEN-1:XLEN-4] != FLAV_CLASSIC && trig_ctrl[g][XLEN-1:XLEN-4] != FLAV_NEWER)
        |-> !hit_vec[g]); // R1
    AST_CLASSIC_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
      (virt && trig_ctrl[g][XLEN-1:XLEN-4] == FLAV_CLASSIC) |-> !hit_vec[g]); // R5
    AST_ACTION_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_ctrl[g][15:12] != 4'd0) |-> !hit_vec[g]); // R7
  end

  bkpt_prio_enc #(.NUM(NUM_TRIG), .IDX_W(IDX_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .req(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkpt_fire <= 1'b0;
      bkpt_idx  <= '0;
    end else begin
      bkpt_fire <= hit_any;
      bkpt_idx  <= hit_any ? hit_idx : '0;
    end
  end

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_valid && !mem_valid) |-> (hit_vec == '0)); // R2
  AST_PRIV_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'd2) |-> (hit_vec == '0)); // R4
  AST_FIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> (bkpt_fire && bkpt_idx == $past(hit_idx))); // R9
  AST_QUIET_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit_vec) |=> (!bkpt_fire && bkpt_idx == '0)); // R9
endmodule

// File: tb/bkpt_addr_match_bench.sv
`timescale 1ns/1ps
module bkpt_addr_match_bench;
  localparam int NT = 4;
  localparam int XL = 32;

  localparam logic [31:0] CL  = 32'h2000_0000;
  localparam logic [31:0] NW  = 32'h6000_0000;
  localparam logic [31:0] BU  = 32'h8, BS = 32'h10, BM = 32'h40, B5 = 32'h20;
  localparam logic [31:0] BVU = 32'h0080_0000, BVS = 32'h0100_0000;
  localparam logic [31:0] LD  = 32'h1, ST = 32'h2, EX = 32'h4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0][XL-1:0] trig_ctrl, trig_cmp;
  logic pc_valid, mem_valid, mem_is_store, virt;
  logic [XL-1:0] pc, mem_addr;
  logic [1:0] priv;
  logic bkpt_fire;
  logic [1:0] bkpt_idx;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bkpt_addr_match u_bkpt_addr_match (
    .clk(clk), .rst_n(rst_n), .trig_ctrl(trig_ctrl), .trig_cmp(trig_cmp),
    .pc_valid(pc_valid), .pc(pc), .mem_valid(mem_valid), .mem_is_store(mem_is_store),
    .mem_addr(mem_addr), .priv(priv), .virt(virt),
    .bkpt_fire(bkpt_fire), .bkpt_idx(bkpt_idx)
  );

  task automatic check(string req, logic ef, logic [1:0] ei);
    total++;
    if (bkpt_fire !== ef || bkpt_idx !== ei) begin
      bad++;
      $display("FAIL %s: fire=%0b idx=%0d expected fire=%0b idx=%0d", req, bkpt_fire, bkpt_idx, ef, ei);
    end
  endtask

  task automatic clear_trigs();
    for (int i = 0; i < NT; i++) begin trig_ctrl[i] = '0; trig_cmp[i] = '0; end
  endtask

  // Present one cycle of stimulus, check the registered result, then idle.
  task automatic probe(string req, logic pv, logic [31:0] a_pc, logic mv, logic st,
                       logic [31:0] a_mem, logic [1:0] p, logic v, logic ef, logic [1:0] ei);
    @(negedge clk);
    pc_valid = pv; pc = a_pc; mem_valid = mv; mem_is_store = st; mem_addr = a_mem;
    priv = p; virt = v;
    @(posedge clk); #1;
    check(req, ef, ei);
    @(negedge clk);
    pc_valid = 0; mem_valid = 0;
  endtask

  task automatic t_reset();
    check("R10", 1'b0, 2'd0);
  endtask

  task automatic t_exec();
    clear_trigs(); trig_ctrl[0] = CL | BM | EX; trig_cmp[0] = 32'h1000;
    probe("R2", 1, 32'h1000, 0, 0, 0, 2'd3, 0, 1, 2'd0);
    probe("R2", 1, 32'h1004, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    probe("R2", 0, 32'h1000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    probe("R3", 0, 0, 1, 0, 32'h1000, 2'd3, 0, 0, 2'd0); // exec-only ignores loads
    @(posedge clk); #1; check("R9", 1'b0, 2'd0);
  endtask

  task automatic t_data();
    clear_trigs(); trig_ctrl[1] = CL | BM | LD; trig_cmp[1] = 32'h2000;
    probe("R3", 0, 0, 1, 0, 32'h2000, 2'd3, 0, 1, 2'd1);
    probe("R3", 0, 0, 1, 1, 32'h2000, 2'd3, 0, 0, 2'd0);
    probe("R3", 0, 0, 1, 0, 32'h2004, 2'd3, 0, 0, 2'd0);
    probe("R2", 1, 32'h2000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    trig_ctrl[1] = CL | BM | ST;
    probe("R3", 0, 0, 1, 1, 32'h2000, 2'd3, 0, 1, 2'd1);
    probe("R3", 0, 0, 1, 0, 32'h2000, 2'd3, 0, 0, 2'd0);
  endtask

  task automatic t_priv();
    clear_trigs(); trig_ctrl[0] = CL | BU | EX; trig_cmp[0] = 32'h3000;
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd0, 0, 1, 2'd0);
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd1, 0, 0, 2'd0);
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    trig_ctrl[0] = CL | BS | EX;
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd1, 0, 1, 2'd0);
    trig_ctrl[0] = CL | BU | BS | BM | B5 | EX;
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd2, 0, 0, 2'd0);
    trig_ctrl[0] = CL | EX;
    probe("R4", 1, 32'h3000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
  endtask

  task automatic t_virt();
    clear_trigs(); trig_ctrl[2] = CL | BU | BS | BM | EX; trig_cmp[2] = 32'h4000;
    probe("R5", 1, 32'h4000, 0, 0, 0, 2'd0, 1, 0, 2'd0);
    probe("R5", 1, 32'h4000, 0, 0, 0, 2'd1, 1, 0, 2'd0);
    probe("R5", 1, 32'h4000, 0, 0, 0, 2'd0, 0, 1, 2'd2);
    trig_ctrl[2] = NW | BVU | EX;
    probe("R6", 1, 32'h4000, 0, 0, 0, 2'd0, 1, 1, 2'd2);
    probe("R6", 1, 32'h4000, 0, 0, 0, 2'd1, 1, 0, 2'd0);
    probe("R6", 1, 32'h4000, 0, 0, 0, 2'd0, 0, 0, 2'd0);
    trig_ctrl[2] = NW | BVS | ST;
    probe("R6", 0, 0, 1, 1, 32'h4000, 2'd1, 1, 1, 2'd2);
    trig_ctrl[2] = NW | BU | BS | BM | EX;
    probe("R6", 1, 32'h4000, 0, 0, 0, 2'd0, 1, 0, 2'd0);
    probe("R6", 1, 32'h4000, 0, 0, 0, 2'd0, 0, 1, 2'd2);
  endtask

  task automatic t_action_type();
    clear_trigs(); trig_ctrl[0] = CL | BM | EX | 32'h1000; trig_cmp[0] = 32'h5000;
    probe("R7", 1, 32'h5000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    trig_ctrl[0] = 32'h3000_0000 | BM | EX;
    probe("R1", 1, 32'h5000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    trig_ctrl[0] = BM | EX;
    probe("R1", 1, 32'h5000, 0, 0, 0, 2'd3, 0, 0, 2'd0);
    trig_ctrl[0] = NW | BM | EX;
    probe("R1", 1, 32'h5000, 0, 0, 0, 2'd3, 0, 1, 2'd0);
  endtask

  task automatic t_prio();
    clear_trigs();
    for (int i = 1; i < NT; i++) begin trig_ctrl[i] = CL | BM | EX; trig_cmp[i] = 32'h6000; end
    probe("R8", 1, 32'h6000, 0, 0, 0, 2'd3, 0, 1, 2'd1);
    trig_ctrl[1] = '0;
    probe("R8", 1, 32'h6000, 0, 0, 0, 2'd3, 0, 1, 2'd2);
    trig_ctrl[2] = '0;
    probe("R8", 1, 32'h6000, 0, 0, 0, 2'd3, 0, 1, 2'd3);
  endtask

  initial begin
    clear_trigs();
    pc_valid = 0; pc = '0; mem_valid = 0; mem_is_store = 0; mem_addr = '0; priv = 2'd3; virt = 0;
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_exec();
    t_data();
    t_priv();
    t_virt();
    t_action_type();
    t_prio();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule